// File: doc/BRIEF.md
# SRAM Bus Cycle Strobe Timer

This block sequences the control strobes of one external static-memory access on a local bus. An internal requester raises a request with a read/write flag, a two-bit interface-type code and, for writes, the data word. The block then drives active-low chip-select, read strobe, write strobe and bus-start strobe through a fixed order of phases: chip-select setup, a strobe phase stretched by a wait count, an optional write hold, and a chip-select release that lands on the falling clock edge. A one-cycle done pulse ends the access. On reads, the data captured at the end of the strobe phase stays on a port after the pulse.

Timing comes from a 16-bit wait-control register with four 3-bit fields: read wait, write wait, bus-start hold and write hold. The write hold adds whole cycles between the end of the write strobe and the chip-select release. The half cycle from the falling-edge release is always added on top. The bus-start hold can stretch the bus-start strobe to two cycles without making the access any longer. A setting outside the allowed range falls back to the short strobe and raises a sticky error flag.

Top module: `sram_strobe_timer`

## Requirements
- R1: After reset the register reads 16'h7000 (write hold 7, every other field 0), cfg_err is 0, done is 0, and cs_n, rd_n, we_n and bs_n are all 1.
- R2: cfg_rdata bits [2:0] hold the read wait, [6:4] the write wait, [10:8] the bus-start hold and [14:12] the write hold. Bits 3, 7, 11 and 15 always read 0, whatever was written to them.
- R3: An access begins with one cycle in which cs_n is 0 and both strobes are 1. This is followed by 1+W cycles with rd_n at 0 (read, W = read wait) or we_n at 0 (write, W = write wait). bus_dout carries the write data captured when the request was accepted.
- R4: For a write with req_if equal to 0, 1 or 2, cs_n rises H+0.5 cycles after we_n rises, where H is the write-hold field (0 to 7).
- R5: For a write with req_if equal to 3, the write-hold field is ignored and cs_n rises 0.5 cycle after we_n.
- R6: For a read, cs_n rises 0.5 cycle after rd_n, whatever the write-hold field holds.
- R7: bs_n is 0 in the first strobe cycle. It is also 0 in the second strobe cycle only when the bus-start hold field is 1 and the wait count for that direction is nonzero. Otherwise it is 0 for one cycle.
- R8: Changing the bus-start hold between 0 and 1 leaves the number of cycles from request to done unchanged.
- R9: A bus-start hold value of 2 to 7 gives a one-cycle bs_n. Writing such a value sets cfg_err, which stays 1 until reset.
- R10: done is 1 for exactly one cycle, the cycle right after the one in which cs_n rose at mid-cycle. For reads, rd_data holds the bus_din value sampled on the rising edge that ends the last rd_n-low cycle.
- R11: A request is taken only while the block is idle. A request held during an access or during the done cycle starts nothing, and the next access begins one cycle after done.
- R12: When a register write and an accepted request fall on the same rising edge, that access uses the field values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; chip-select release uses its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the wait-control register |
| cfg_wdata | input | 16 | Register write value |
| cfg_rdata | output | 16 | Register read value, reserved bits 0 |
| cfg_err | output | 1 | Sticky flag for a prohibited bus-start hold value |
| req | input | 1 | Access request, taken when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_if | input | 2 | Interface type; 0, 1, 2 honour write hold, 3 does not |
| req_wdata | input | 16 | Write data captured on acceptance |
| bus_din | input | 16 | Read data from the external device |
| bus_dout | output | 16 | Write data toward the external device |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| bs_n | output | 1 | Bus-start strobe, active low |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 16 | Data latched by the last read |

## Verification
Two events can share one rising edge. A register write can coincide with the acceptance of a request, and a pending request can coincide with the done cycle of the previous access. The bench provokes the first by issuing a write access and a new register value in the same cycle; the strobe lengths must then follow the old fields. It provokes the second by holding req high across several accesses; the next setup cycle must start only one cycle after done. A cycle-by-cycle reference model checks both, sampling chip-select in each half of every cycle.

// File: rtl/sst_pkg.sv
`timescale 1ns/1ps
package sst_pkg;
  localparam int FW     = 3;
  localparam int SLOT   = FW + 1;
  localparam int NFLD   = 4;
  localparam int CFG_W  = NFLD * SLOT;

  localparam int IDX_RDW = 0;
  localparam int IDX_WRW = 1;
  localparam int IDX_BSH = 2;
  localparam int IDX_WEH = 3;

  localparam logic [FW-1:0] BSH_TWO  = FW'(1);
  localparam logic [1:0]    IF_OTHER = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_RELEASE, ST_DONE
  } st_e;

  typedef struct packed {
    logic [FW-1:0] we_hold;
    logic [FW-1:0] bs_hold;
    logic [FW-1:0] wr_wait;
    logic [FW-1:0] rd_wait;
  } cfg_t;
endpackage

// File: rtl/sst_reset_sync.sv
`timescale 1ns/1ps
module sst_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/sst_cfg_reg.sv
`timescale 1ns/1ps
module sst_cfg_reg
  import sst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output cfg_t             cfg,
  output logic             err
);
  logic [FW-1:0] fld_q [NFLD];
  logic [FW-1:0] fld_d [NFLD];
  logic          err_d;
  logic          err_q;

  always_comb begin
    for (int i = 0; i < NFLD; i++) begin
      fld_d[i] = wr_en ? wdata[i*SLOT +: FW] : fld_q[i];
    end
    err_d = err_q | (wr_en && (wdata[IDX_BSH*SLOT +: FW] > BSH_TWO));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFLD; i++) begin
        fld_q[i] <= (i == IDX_WEH) ? {FW{1'b1}} : '0;
      end
      err_q <= 1'b0;
    end else begin
      for (int i = 0; i < NFLD; i++) begin
        fld_q[i] <= fld_d[i];
      end
      err_q <= err_d;
    end
  end

  generate
    for (genvar g = 0; g < NFLD; g++) begin : g_rd
      assign rdata[g*SLOT +: FW] = fld_q[g];
      assign rdata[g*SLOT + FW]  = 1'b0;
    end
  endgenerate

  assign cfg.rd_wait = fld_q[IDX_RDW];
  assign cfg.wr_wait = fld_q[IDX_WRW];
  assign cfg.bs_hold = fld_q[IDX_BSH];
  assign cfg.we_hold = fld_q[IDX_WEH];
  assign err         = err_q;
endmodule

// File: rtl/sst_sequencer.sv
`timescale 1ns/1ps
module sst_sequencer
  import sst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [1:0]        req_if,
  input  logic [DATA_W-1:0] req_wdata,
  input  cfg_t              cfg,
  input  logic [DATA_W-1:0] bus_din,
  output logic              rd_n,
  output logic              we_n,
  output logic              bs_n,
  output logic              cs_main,
  output logic              cs_rel,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] bus_dout
);
  st_e               st_q, st_d;
  logic [FW-1:0]     cnt_q, cnt_d;
  logic [FW-1:0]     wait_q, wait_d;
  logic [FW-1:0]     hold_q, hold_d;
  logic              wr_q, wr_d;
  logic              bs2_q, bs2_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    wait_d = wait_q;
    hold_d = hold_q;
    wr_d   = wr_q;
    bs2_d  = bs2_q;
    dout_d = dout_q;
    rdat_d = rdat_q;
    case (st_q)
      ST_IDLE: begin
        if (req) begin
          st_d   = ST_SETUP;
          wr_d   = req_write;
          wait_d = req_write ? cfg.wr_wait : cfg.rd_wait;
          hold_d = (req_write && (req_if != IF_OTHER)) ? cfg.we_hold : '0;
          bs2_d  = (cfg.bs_hold == BSH_TWO) && (wait_d != '0);
          dout_d = req_wdata;
          cnt_d  = '0;
        end
      end
      ST_SETUP: begin
        st_d  = ST_STROBE;
        cnt_d = '0;
      end
      ST_STROBE: begin
        if (cnt_q == wait_q) begin
          if (!wr_q) rdat_d = bus_din;
          cnt_d = FW'(1);
          st_d  = (hold_q != '0) ? ST_HOLD : ST_RELEASE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_q == hold_q) st_d = ST_RELEASE;
        else                 cnt_d = cnt_q + 1'b1;
      end
      ST_RELEASE: st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      wait_q <= '0;
      hold_q <= '0;
      wr_q   <= 1'b0;
      bs2_q  <= 1'b0;
      dout_q <= '0;
      rdat_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wait_q <= wait_d;
      hold_q <= hold_d;
      wr_q   <= wr_d;
      bs2_q  <= bs2_d;
      dout_q <= dout_d;
      rdat_q <= rdat_d;
    end
  end

  logic in_strobe;
  assign in_strobe = (st_q == ST_STROBE);
  assign rd_n      = ~(in_strobe & ~wr_q);
  assign we_n      = ~(in_strobe & wr_q);
  assign bs_n      = ~(in_strobe & ((cnt_q == '0) | (bs2_q & (cnt_q == FW'(1)))));
  assign cs_main   = (st_q == ST_SETUP) | in_strobe | (st_q == ST_HOLD);
  assign cs_rel    = (st_q == ST_RELEASE);
  assign done      = (st_q == ST_DONE);
  assign rd_data   = rdat_q;
  assign bus_dout  = dout_q;
endmodule

// File: rtl/sst_cs_release.sv
`timescale 1ns/1ps
module sst_cs_release (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_main,
  input  logic cs_rel,
  output logic cs_n
);
  logic keep_q;
  logic keep_d;

  always_comb keep_d = cs_main;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) keep_q <= 1'b0;
    else        keep_q <= keep_d;
  end

  assign cs_n = ~(cs_main | (cs_rel & keep_q));
endmodule

// File: rtl/sram_strobe_timer.sv
`timescale 1ns/1ps
module sram_strobe_timer
  import sst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              cfg_err,
  input  logic              req,
  input  logic              req_write,
  input  logic [1:0]        req_if,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              cs_n,
  output logic              rd_n,
  output logic              we_n,
  output logic              bs_n,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  logic rst_ni;
  cfg_t cfg;
  logic cs_main;
  logic cs_rel;

  sst_reset_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  sst_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_ni),
    .wr_en (cfg_wr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg),
    .err   (cfg_err)
  );

  sst_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .req       (req),
    .req_write (req_write),
    .req_if    (req_if),
    .req_wdata (req_wdata),
    .cfg       (cfg),
    .bus_din   (bus_din),
    .rd_n      (rd_n),
    .we_n      (we_n),
    .bs_n      (bs_n),
    .cs_main   (cs_main),
    .cs_rel    (cs_rel),
    .done      (done),
    .rd_data   (rd_data),
    .bus_dout  (bus_dout)
  );

  sst_cs_release u_cs (
    .clk     (clk),
    .rst_n   (rst_ni),
    .cs_main (cs_main),
    .cs_rel  (cs_rel),
    .cs_n    (cs_n)
  );
endmodule

// File: rtl/sst_chk.sv
`timescale 1ns/1ps
module sst_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rd_n,
  input logic we_n,
  input logic bs_n,
  input logic done,
  input logic cfg_err
);
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !we_n));

  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !we_n) |-> !cs_n);

  assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (rd_n && we_n));

  assert_bs_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bs_n |-> (!rd_n || !we_n));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cs_n) && !$past(cs_n, 2)));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind sram_strobe_timer sst_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .rd_n    (rd_n),
  .we_n    (we_n),
  .bs_n    (bs_n),
  .done    (done),
  .cfg_err (cfg_err)
);

// File: tb/sram_strobe_timer_tb.sv
`timescale 1ns/1ps
module sram_strobe_timer_tb;
  localparam int DW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr;
  logic [CW-1:0] cfg_wdata;
  logic [CW-1:0] cfg_rdata;
  logic          cfg_err;
  logic          req, req_write;
  logic [1:0]    req_if;
  logic [DW-1:0] req_wdata, bus_din, bus_dout, rd_data;
  logic          cs_n, rd_n, we_n, bs_n, done;

  always #10 clk = ~clk;

  sram_strobe_timer #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .req(req), .req_write(req_write),
    .req_if(req_if), .req_wdata(req_wdata), .bus_din(bus_din), .bus_dout(bus_dout),
    .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n), .bs_n(bs_n), .done(done), .rd_data(rd_data)
  );

  typedef struct {
    logic csa, csb, rdn, wen, bsn, dn;
    logic chk_rd; logic [DW-1:0] rdx;
    logic chk_wd; logic [DW-1:0] wdx;
    string cs_tag, st_tag, bs_tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  logic [2:0] m_rdw, m_wrw, m_bs, m_weh;
  logic m_err;
  logic obs_done;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t mk(logic csa, logic csb, logic rdn, logic wen, logic bsn,
                              logic dn, string ct, string stt, string bt);
    exp_t e;
    e.csa = csa; e.csb = csb; e.rdn = rdn; e.wen = wen; e.bsn = bsn; e.dn = dn;
    e.chk_rd = 1'b0; e.rdx = '0; e.chk_wd = 1'b0; e.wdx = '0;
    e.cs_tag = ct; e.st_tag = stt; e.bs_tag = bt;
    return e;
  endfunction

  function automatic logic [CW-1:0] exp_rdata();
    return {1'b0, m_weh, 1'b0, m_bs, 1'b0, m_wrw, 1'b0, m_rdw};
  endfunction

  task automatic push_access(logic wr, int ift, logic [DW-1:0] wd,
                             logic [DW-1:0] din, string ovr);
    int w, h, bl;
    string ct, stt, bt;
    exp_t e;
    w  = wr ? int'(m_wrw) : int'(m_rdw);
    h  = (wr && ift != 3) ? int'(m_weh) : 0;
    bl = (m_bs == 3'd1 && w != 0) ? 2 : 1;
    ct  = wr ? ((ift != 3) ? "R4" : "R5") : "R6";
    stt = "R3";
    bt  = (m_bs > 3'd1) ? "R9" : "R7";
    if (ovr != "") begin ct = ovr; stt = ovr; bt = ovr; end
    q.push_back(mk(0, 0, 1, 1, 1, 0, ct, stt, bt));
    for (int i = 0; i <= w; i++) begin
      e = mk(0, 0, wr, !wr, (i >= bl), 0, ct, stt, bt);
      e.chk_wd = wr; e.wdx = wd;
      q.push_back(e);
    end
    for (int i = 0; i < h; i++) q.push_back(mk(0, 0, 1, 1, 1, 0, ct, stt, bt));
    q.push_back(mk(0, 1, 1, 1, 1, 0, ct, stt, bt));
    e = mk(1, 1, 1, 1, 1, 1, ct, stt, bt);
    e.chk_rd = !wr; e.rdx = din;
    q.push_back(e);
  endtask

  task automatic step(logic rq, logic wr, int ift, logic [DW-1:0] wd,
                      logic cw, logic [CW-1:0] cd, string ovr);
    exp_t e;
    logic was_idle;
    @(posedge clk);
    #5;
    if (q.size() > 0) begin e = q.pop_front(); was_idle = 1'b0; end
    else begin e = mk(1, 1, 1, 1, 1, 0, "R11", "R11", "R11"); was_idle = 1'b1; end
    obs_done = done;
    chk(e.cs_tag, "cs_n first half", int'(cs_n), int'(e.csa));
    chk(e.st_tag, "rd_n", int'(rd_n), int'(e.rdn));
    chk(e.st_tag, "we_n", int'(we_n), int'(e.wen));
    chk(e.bs_tag, "bs_n", int'(bs_n), int'(e.bsn));
    chk("R10", "done", int'(done), int'(e.dn));
    if (e.chk_rd) chk("R10", "rd_data", int'(rd_data), int'(e.rdx));
    if (e.chk_wd) chk("R3", "bus_dout", int'(bus_dout), int'(e.wdx));
    chk("R2", "cfg_rdata", int'(cfg_rdata), int'(exp_rdata()));
    chk("R9", "cfg_err", int'(cfg_err), int'(m_err));
    req = rq; req_write = wr; req_if = 2'(ift); req_wdata = wd;
    cfg_wr = cw; cfg_wdata = cd;
    if (rq && was_idle) push_access(wr, ift, wd, bus_din, ovr);
    if (cw) begin
      m_rdw = cd[2:0]; m_wrw = cd[6:4]; m_bs = cd[10:8]; m_weh = cd[14:12];
      if (cd[10:8] > 3'd1) m_err = 1'b1;
    end
    #10;
    chk(e.cs_tag, "cs_n second half", int'(cs_n), int'(e.csb));
  endtask

  task automatic idle_step();
    step(0, 0, 0, '0, 0, '0, "");
  endtask

  task automatic cfg_write(logic [CW-1:0] v);
    step(0, 0, 0, '0, 1, v, "");
    idle_step();
  endtask

  task automatic access(logic wr, int ift, logic [DW-1:0] wd, logic [DW-1:0] din,
                        string ovr, output int lat);
    bus_din = din;
    step(1, wr, ift, wd, 0, '0, ovr);
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      idle_step();
      lat++;
      if (obs_done) break;
    end
    idle_step();
  endtask

  int lat_a, lat_b;

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; req = 1'b0; req_write = 1'b0;
    req_if = 2'd0; req_wdata = '0; bus_din = '0; obs_done = 1'b0;
    m_rdw = 3'd0; m_wrw = 3'd0; m_bs = 3'd0; m_weh = 3'd7; m_err = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    rst_n = 1'b1;
    #2;
    // R1: state right after reset release
    chk("R1", "cfg_rdata reset", int'(cfg_rdata), 16'h7000);
    chk("R1", "cfg_err reset", int'(cfg_err), 0);
    chk("R1", "outputs idle", int'({cs_n, rd_n, we_n, bs_n, done}), 5'b11110);
    repeat (3) idle_step();

    // R4: default write hold 7 gives 7.5 cycles
    access(1, 0, 16'hA5A5, 16'h0000, "", lat_a);
    // R6: read with default fields
    access(0, 0, 16'h0000, 16'h1234, "", lat_a);

    // R2 and R9: reserved bits written as ones, prohibited bus-start hold
    cfg_write(16'hFFFF);
    access(1, 1, 16'h5A5A, 16'h0000, "", lat_a);
    access(0, 2, 16'h0000, 16'hBEEF, "", lat_a);

    // R7: read wait 2, write wait 3, hold field 1, write hold 2; error stays set
    cfg_write(16'h2132);
    access(0, 0, 16'h0000, 16'hC0DE, "", lat_a);
    access(1, 0, 16'h1111, 16'h0000, "", lat_a);
    access(1, 1, 16'h2222, 16'h0000, "", lat_a);
    access(1, 2, 16'h3333, 16'h0000, "", lat_a);
    // R5: interface type 3 ignores write hold
    access(1, 3, 16'h4444, 16'h0000, "", lat_b);

    // R8: same access with bus-start hold 0 and 1
    access(1, 0, 16'h5555, 16'h0000, "", lat_a);
    cfg_write(16'h2032);
    access(1, 0, 16'h6666, 16'h0000, "", lat_b);
    chk("R8", "write latency bs stretch", lat_a, lat_b);
    access(0, 0, 16'h0000, 16'h7777, "", lat_b);
    cfg_write(16'h2132);
    access(0, 0, 16'h0000, 16'h8888, "", lat_a);
    chk("R8", "read latency bs stretch", lat_a, lat_b);

    // R7: zero read wait keeps bs_n short even with hold field 1
    cfg_write(16'h2130);
    access(0, 1, 16'h0000, 16'h9999, "", lat_a);

    // R4: write hold 0 gives the half cycle only
    cfg_write(16'h0132);
    access(1, 0, 16'hABCD, 16'h0000, "", lat_a);

    // R12: register write on the accepting edge
    bus_din = 16'h0F0F;
    step(1, 1, 0, 16'hD00D, 1, 16'h5017, "R12");
    for (int k = 0; k < 30; k++) idle_step();
    access(1, 0, 16'hE00E, 16'h0000, "", lat_a);

    // R11: request held high across several accesses
    bus_din = 16'h3C3C;
    for (int k = 0; k < 40; k++) step(1, (k % 2) == 1, k % 4, 16'(k), 0, '0, "R11");
    for (int k = 0; k < 30; k++) idle_step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule